// File: doc/BRIEF.md
# DDR Command Spacing and Bank State Monitor

This block sits beside a memory controller and watches the command pins of a four-bank DDR SDRAM. It samples clock enable, chip select, the three strobe pins, the two bank-select bits and the A10 address bit on every rising clock edge. From these it decodes one command per clock and keeps track of which banks have a row open. No command is driven back onto the bus.

Every command is checked against two kinds of rule. The state rules cover which banks must be open, closed or all idle for that command. The spacing rules give the minimum number of clocks to the earlier commands it depends on. All spacing limits are parameters counted in clocks. The block reports the decoded command and the open-bank vector. When a rule is broken it raises a one-cycle hit flag and keeps an error code until software-side logic pulses a clear input.

The monitor is meant for integration checks and for silicon debug. It gives a controller's command scheduler a cycle-accurate second opinion without touching the data path.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: One clock after a command is sampled, `cmd_q` shows its code. With clock enable high and chip select low, the pin pattern {ras_n,cas_n,we_n} maps as follows: 000 gives 1 (mode set), 001 gives 2 (refresh), 011 gives 3 (activate), 101 gives 4 (read), 100 gives 5 (write), 110 gives 6 (burst stop) and 010 gives 7 (precharge). Pattern 111, chip select high, or clock enable low gives 0 (idle).
- R2: `bank_open[i]` refers to the bank whose select value `ba` equals i. An activate sets that bit. A precharge clears it, or clears every bit when `a10` is high. A read or write with `a10` high (auto-precharge) clears it as well.
- R3: Any command other than idle that arrives fewer than T_MRD clocks after a mode set is a violation with code 1.
- R4: A mode set or a refresh issued while any bank is open is a violation with code 2.
- R5: A read or write to a closed bank is a violation with code 3. So is an activate to a bank that is already open.
- R6: A write with auto-precharge blocks all banks for BURST_LEN/2 clocks. A read or write issued fewer than BURST_LEN/2 clocks after it is a violation with code 4.
- R7: A read or write issued fewer than T_RCD clocks after the activate of its bank is a violation with code 5.
- R8: A precharge that closes an open bank fewer than T_RAS clocks after that bank's activate is a violation with code 6.
- R9: An activate is a violation with code 7 in three cases: it comes fewer than T_RC clocks after the previous activate of the same bank; it comes fewer than T_RRD clocks after an activate to a different bank; or it comes fewer than BURST_LEN/2+T_RP clocks after a write with auto-precharge to its bank.
- R10: When several rules fail on one command, the lowest code wins. `err_hit` is high for one cycle, one clock after each violating command. `err_code` captures the first violation and holds it through later ones. A cycle with `err_clr` high loads the code of that cycle's own violation, or 0 if there is none.
- R11: After reset, `cmd_q`, `bank_open`, `err_hit` and `err_code` are all zero, and every spacing window counts as already elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin; low makes the cycle idle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| err_clr | input | 1 | Clears the held error code |
| cmd_q | output | 3 | Decoded command code |
| bank_open | output | 4 | Open-row flag per bank |
| err_hit | output | 1 | One-cycle pulse per violating command |
| err_code | output | 3 | First violation code since the last clear |

## Verification
The hardest case to reach is the write with auto-precharge, because its two windows overlap other rules. A read inside the blocking window could also break the column delay, and a re-activate inside the precharge window could also break the row cycle. The stimulus therefore opens the banks and waits a full row cycle before the write. It then sweeps the gap to the following read, or to the re-activate, one clock at a time, so that only the window under test can fire. Every other spacing rule is swept the same way, across its limit from one clock to one clock past the limit.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;
  localparam int NUM_BANKS = 4;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_MRS = 3'd1,
    CMD_REF = 3'd2,
    CMD_ACT = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5,
    CMD_BST = 3'd6,
    CMD_PRE = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_MRD   = 3'd1,
    ERR_IDLE  = 3'd2,
    ERR_STATE = 3'd3,
    ERR_WAP   = 3'd4,
    ERR_RCD   = 3'd5,
    ERR_RAS   = 3'd6,
    ERR_ACT   = 3'd7
  } err_e;
endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
  import ddrmon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank
  import ddrmon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic sel,
  input  logic a10,
  output logic is_open,
  output logic wap_busy,
  output logic v_state,
  output logic v_rcd,
  output logic v_ras,
  output logic v_act
);
  localparam int HALF = BURST_LEN / 2;
  localparam int BLK  = HALF + T_RP;
  localparam int AW   = $clog2(T_RC + 1);
  localparam int BW   = $clog2(BLK + 1);
  localparam logic [AW-1:0] AGE_SAT  = AW'(T_RC);
  localparam logic [BW-1:0] BLK_INIT = BW'(BLK - 1);
  localparam logic [BW-1:0] RP_LIM   = BW'(T_RP);

  logic          open_q, open_d;
  logic [AW-1:0] age_q, age_d;
  logic [BW-1:0] blk_q, blk_d;
  logic          age_en, blk_en;
  logic          hit_act, hit_pre, hit_col, hit_wap;

  assign hit_act = (cmd == CMD_ACT) && sel;
  assign hit_pre = (cmd == CMD_PRE) && (sel || a10);
  assign hit_col = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
  assign hit_wap = (cmd == CMD_WR) && sel && a10;

  always_comb begin
    open_d = open_q;
    if (hit_act)                open_d = 1'b1;
    else if (hit_pre)           open_d = 1'b0;
    else if (hit_col && a10)    open_d = 1'b0;

    age_en = hit_act || (age_q < AGE_SAT);
    age_d  = hit_act ? AW'(1) : age_q + AW'(1);

    blk_en = hit_wap || (blk_q != '0);
    blk_d  = hit_wap ? BLK_INIT : blk_q - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      age_q  <= AGE_SAT;
      blk_q  <= '0;
    end else begin
      open_q <= open_d;
      if (age_en) age_q <= age_d;
      if (blk_en) blk_q <= blk_d;
    end
  end

  assign is_open  = open_q;
  assign wap_busy = blk_q > RP_LIM;
  assign v_state  = (hit_col && !open_q) || (hit_act && open_q);
  assign v_rcd    = hit_col && open_q && (age_q < AW'(T_RCD));
  assign v_ras    = hit_pre && open_q && (age_q < AW'(T_RAS));
  assign v_act    = hit_act && ((age_q < AGE_SAT) || (blk_q != '0));
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  input  logic       err_clr,
  output logic [2:0] cmd_q,
  output logic [3:0] bank_open,
  output logic       err_hit,
  output logic [2:0] err_code
);
  localparam int MW = $clog2(T_MRD + 1);
  localparam int RW = $clog2(T_RRD + 1);
  localparam logic [RW-1:0] RRD_SAT = RW'(T_RRD);

  cmd_e cmd;
  logic [NUM_BANKS-1:0] open_w, busy_w, vs_w, vrcd_w, vras_w, vact_w;

  ddrmon_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    ddrmon_bank #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(ba == 2'(g)), .a10(a10),
      .is_open(open_w[g]), .wap_busy(busy_w[g]), .v_state(vs_w[g]),
      .v_rcd(vrcd_w[g]), .v_ras(vras_w[g]), .v_act(vact_w[g])
    );
  end

  logic [MW-1:0] mrd_q, mrd_d;
  logic          mrd_en;
  logic [RW-1:0] rrd_q, rrd_d;
  logic          rrd_en;
  logic [1:0]    last_ba_q;
  logic          v_mrd, v_idle, v_wap, v_rrd, is_col;
  err_e          code_d;
  logic [2:0]    code_nx;

  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign v_mrd  = (cmd != CMD_NOP) && (mrd_q != '0);
  assign v_idle = ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_w);
  assign v_wap  = is_col && (|busy_w);
  assign v_rrd  = (cmd == CMD_ACT) && (ba != last_ba_q) && (rrd_q < RRD_SAT);

  always_comb begin
    mrd_en = (cmd == CMD_MRS) || (mrd_q != '0);
    mrd_d  = (cmd == CMD_MRS) ? MW'(T_MRD - 1) : mrd_q - MW'(1);
    rrd_en = (cmd == CMD_ACT) || (rrd_q < RRD_SAT);
    rrd_d  = (cmd == CMD_ACT) ? RW'(1) : rrd_q + RW'(1);

    code_d = ERR_NONE;
    if (v_mrd)                   code_d = ERR_MRD;
    else if (v_idle)             code_d = ERR_IDLE;
    else if (|vs_w)              code_d = ERR_STATE;
    else if (v_wap)              code_d = ERR_WAP;
    else if (|vrcd_w)            code_d = ERR_RCD;
    else if (|vras_w)            code_d = ERR_RAS;
    else if ((|vact_w) || v_rrd) code_d = ERR_ACT;

    code_nx = err_code;
    if (err_clr || (err_code == 3'd0)) code_nx = code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrd_q     <= '0;
      rrd_q     <= RRD_SAT;
      last_ba_q <= '0;
      cmd_q     <= '0;
      err_hit   <= 1'b0;
      err_code  <= '0;
    end else begin
      if (mrd_en) mrd_q <= mrd_d;
      if (rrd_en) rrd_q <= rrd_d;
      if (cmd == CMD_ACT) last_ba_q <= ba;
      cmd_q    <= cmd;
      err_hit  <= (code_d != ERR_NONE);
      err_code <= code_nx;
    end
  end

  assign bank_open = open_w;
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk #(
  parameter int T_MRD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic       err_clr,
  input logic [2:0] cmd_q,
  input logic [3:0] bank_open,
  input logic       err_hit,
  input logic [2:0] err_code
);
  logic live, act_in, pre_all_in, col_in, mrs_in, mrs_prev;

  assign live       = cke && !cs_n && !(ras_n && cas_n && we_n);
  assign act_in     = cke && !cs_n && !ras_n && cas_n && we_n;
  assign pre_all_in = cke && !cs_n && !ras_n && cas_n && !we_n && a10;
  assign col_in     = cke && !cs_n && ras_n && !cas_n;
  assign mrs_in     = cke && !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mrs_prev <= 1'b0;
    else        mrs_prev <= mrs_in;
  end

  assert_idle_when_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (cmd_q == 3'd0));

  assert_act_opens_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_in |=> bank_open[$past(ba)]);

  assert_pre_all_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_in |=> (bank_open == 4'd0));

  assert_mrd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_MRD >= 2) && mrs_prev && live) |=> (err_hit && (err_code != 3'd0)));

  assert_col_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_in && !bank_open[ba]) |=> err_hit);

  assert_code_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_code != 3'd0) && !err_clr) |=> (err_code == $past(err_code)));

  assert_hit_has_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |-> (err_code != 3'd0));
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.T_MRD(T_MRD)) u_chk (.*);

// File: tb/ddr_cmd_monitor_tb.sv
module ddr_cmd_monitor_tb;
  localparam int T_RCD = 3, T_RRD = 2, T_RAS = 6, T_RC = 9, T_RP = 3, T_MRD = 2, BL = 4;
  localparam logic [3:0] E_MRS = 4'b0000, E_REF = 4'b0001, E_ACT = 4'b0011, E_RD = 4'b0101,
                         E_WR = 4'b0100, E_PRE = 4'b0010, E_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, a10, err_clr;
  logic [1:0] ba;
  logic [2:0] cmd_q, err_code;
  logic [3:0] bank_open;
  logic err_hit;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_cmd_monitor #(.T_RCD(T_RCD), .T_RRD(T_RRD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
                    .T_MRD(T_MRD), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_clr(err_clr), .cmd_q(cmd_q),
    .bank_open(bank_open), .err_hit(err_hit), .err_code(err_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic ap, input logic clr);
    {cs_n, ras_n, cas_n, we_n} = c; ba = b; a10 = ap; err_clr = clr;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = E_NOP; a10 = 1'b0; err_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) issue(E_NOP, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic settle();
    issue(E_PRE, 2'd0, 1'b1, 1'b0);
    idle(24);
    issue(E_NOP, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic chk_err(input string req, input bit bad, input int code);
    chk({req, " hit"}, int'(err_hit), int'(bad));
    chk({req, " code"}, int'(err_code), bad ? code : 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = E_NOP; ba = '0; a10 = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 cmd", int'(cmd_q), 0);
    chk("R11 open", int'(bank_open), 0);
    chk("R11 hit", int'(err_hit), 0);
    chk("R11 code", int'(err_code), 0);

    // R1: every pin pattern, then clock enable low
    for (int v = 0; v < 16; v++) begin
      int exp;
      issue(v[3:0], 2'd0, 1'b0, 1'b0);
      if (v[3]) exp = 0;
      else case (v[2:0])
        3'b000: exp = 1; 3'b001: exp = 2; 3'b011: exp = 3; 3'b101: exp = 4;
        3'b100: exp = 5; 3'b110: exp = 6; 3'b010: exp = 7; default: exp = 0;
      endcase
      chk("R1 decode", int'(cmd_q), exp);
    end
    cke = 1'b0;
    issue(E_ACT, 2'd1, 1'b0, 1'b0);
    chk("R1 cke low", int'(cmd_q), 0);
    cke = 1'b1;
    settle();

    // R2: open and close tracking
    issue(E_ACT, 2'd1, 1'b0, 1'b0); idle(T_RRD - 1);
    issue(E_ACT, 2'd3, 1'b0, 1'b0); idle(T_RRD - 1);
    issue(E_ACT, 2'd2, 1'b0, 1'b0);
    chk("R2 open three", int'(bank_open), 4'b1110);
    idle(T_RC);
    issue(E_PRE, 2'd3, 1'b0, 1'b0);
    chk("R2 single close", int'(bank_open), 4'b0110);
    issue(E_RD, 2'd1, 1'b1, 1'b0);
    chk("R2 read ap close", int'(bank_open), 4'b0100);
    issue(E_PRE, 2'd0, 1'b1, 1'b0);
    chk("R2 all close", int'(bank_open), 0);
    chk("R2 no error", int'(err_code), 0);
    settle();

    // R3: mode set gap sweep
    for (int k = 1; k <= T_MRD + 1; k++) begin
      issue(E_MRS, 2'd0, 1'b0, 1'b0); idle(k - 1);
      issue(E_REF, 2'd0, 1'b0, 1'b0);
      chk_err("R3 mrd", k < T_MRD, 1);
      settle();
    end

    // R4: idle precondition
    issue(E_ACT, 2'd0, 1'b0, 1'b0); idle(T_RC);
    issue(E_REF, 2'd0, 1'b0, 1'b0);
    chk_err("R4 refresh open", 1, 2);
    settle();

    // R5: state errors
    issue(E_RD, 2'd2, 1'b0, 1'b0);
    chk_err("R5 read closed", 1, 3);
    issue(E_NOP, 2'd0, 1'b0, 1'b1);
    issue(E_ACT, 2'd2, 1'b0, 1'b0); idle(T_RC);
    issue(E_ACT, 2'd2, 1'b0, 1'b0);
    chk_err("R5 act open", 1, 3);
    settle();

    // R7: activate to column sweep
    for (int k = 1; k <= T_RCD + 1; k++) begin
      issue(E_ACT, 2'd0, 1'b0, 1'b0); idle(k - 1);
      issue(E_RD, 2'd0, 1'b0, 1'b0);
      chk_err("R7 rcd", k < T_RCD, 5);
      settle();
    end

    // R8: activate to precharge sweep
    for (int k = 1; k <= T_RAS + 1; k++) begin
      issue(E_ACT, 2'd1, 1'b0, 1'b0); idle(k - 1);
      issue(E_PRE, 2'd1, 1'b0, 1'b0);
      chk_err("R8 ras", k < T_RAS, 6);
      settle();
    end

    // R9: same-bank row cycle sweep
    for (int k = T_RAS + 1; k <= T_RC + 1; k++) begin
      issue(E_ACT, 2'd2, 1'b0, 1'b0); idle(T_RAS - 1);
      issue(E_PRE, 2'd2, 1'b0, 1'b0); idle(k - T_RAS - 1);
      issue(E_ACT, 2'd2, 1'b0, 1'b0);
      chk_err("R9 rc", k < T_RC, 7);
      settle();
    end

    // R9: different-bank activate sweep
    for (int k = 1; k <= T_RRD + 1; k++) begin
      issue(E_ACT, 2'd0, 1'b0, 1'b0); idle(k - 1);
      issue(E_ACT, 2'd3, 1'b0, 1'b0);
      chk_err("R9 rrd", k < T_RRD, 7);
      settle();
    end

    // R6: write with auto-precharge blocks column commands
    for (int k = 1; k <= BL / 2 + 1; k++) begin
      issue(E_ACT, 2'd1, 1'b0, 1'b0); idle(T_RRD - 1);
      issue(E_ACT, 2'd0, 1'b0, 1'b0); idle(T_RC);
      issue(E_WR, 2'd0, 1'b1, 1'b0);
      chk("R6 wr ap closes", int'(bank_open), 4'b0010);
      idle(k - 1);
      issue(E_RD, 2'd1, 1'b0, 1'b0);
      chk_err("R6 wap", k < BL / 2, 4);
      settle();
    end

    // R9: re-activate after write with auto-precharge
    for (int m = 1; m <= BL / 2 + T_RP + 1; m++) begin
      issue(E_ACT, 2'd0, 1'b0, 1'b0); idle(T_RC);
      issue(E_WR, 2'd0, 1'b1, 1'b0); idle(m - 1);
      issue(E_ACT, 2'd0, 1'b0, 1'b0);
      chk_err("R9 rp", m < BL / 2 + T_RP, 7);
      settle();
    end

    // R10: priority, clear-cycle load, holding
    issue(E_ACT, 2'd0, 1'b0, 1'b0); idle(T_RC);
    issue(E_MRS, 2'd0, 1'b0, 1'b0);
    chk_err("R10 first", 1, 2);
    issue(E_REF, 2'd0, 1'b0, 1'b1);
    chk_err("R10 priority on clear", 1, 1);
    idle(2);
    issue(E_RD, 2'd3, 1'b0, 1'b0);
    chk("R10 held hit", int'(err_hit), 1);
    chk("R10 held code", int'(err_code), 1);
    issue(E_NOP, 2'd0, 1'b0, 1'b1);
    chk_err("R10 cleared", 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule